// File: doc/BRIEF.md
# DRAM Controller Indirect Register Window

This block is the configuration and status register bank of a four-bank DRAM controller. It is reached over a simple register bus through only two ports. A write to the selector port stores an internal register offset. Reads and writes on the window port then act on the register that offset selects. Software sets the selector once and can then make any number of window accesses to that register.

Behind the window sit these registers: two bus-error status words with write-one-to-clear bits, an error address, the main configuration word, a read-only status word, refresh, power-management, timing and ECC-configuration words, an ECC error word that drives an interrupt, and one configuration word per DRAM bank. The configuration word drives a global enable to the bank decoders. Its enable bit and one mode bit are reflected in the status word. The timing word and the bank words are forwarded on output ports to the neighbouring logic.

Every request gets a one-cycle acknowledge. Read data is registered and is valid with that acknowledge.

Top module: `dram_csr_window`

## Requirements
- R1: After synchronous reset, all of the following hold. The selector reads 0. The configuration word reads 0x00800000, power-management 0x07C00000, refresh 0x05F00000 and the timing output 0x00854009. Every other register reads 0. The interrupt and the global enable are low.
- R2: A request is acknowledged exactly one cycle after it is presented, and read data is valid with the acknowledge. A write to port 0x10 stores the low 8 bits as the offset, and a read of port 0x10 returns that offset zero-extended. Port 0x11 reads and writes the register at the stored offset. A request on any other port is acknowledged, returns 0 on a read and changes nothing.
- R3: The bus-error status words at offsets 0x00 and 0x08 clear every bit that is 1 in the written value. The error address at 0x10 stores all 32 bits.
- R4: A write to the configuration word at 0x20 keeps only bits 31:21. When bit 31 goes from 0 to 1, status bit 31 clears and the global enable rises. When bit 31 goes from 1 to 0, status bit 31 sets and the global enable falls.
- R5: Status bit 30 sets when configuration bit 30 rises and clears when it falls. Writes to the status word at 0x24 have no effect.
- R6: Refresh (0x30) keeps the written bits under mask 0x3FF80000. ECC configuration (0x94) keeps mask 0x00F00000. ECC error (0x98) keeps mask 0xFFF0F000.
- R7: Power-management (0x34) stores written bits 31:27 and always reads with bits 26:22 set.
- R8: The interrupt rises when a write takes the masked ECC error word from zero to nonzero. It falls when a write takes it from nonzero to zero. Otherwise it holds its level.
- R9: The timing word (0x80) stores the written value under mask 0x018FC01F and drives the timing output. A window read of it returns 0xFFFFFFFF, as does a read of any offset that is not mapped.
- R10: Bank word i sits at offset 0x40+4*i. It stores the written value under mask 0xFFDEE001, reads back that value and drives bits 32*i+31:32*i of the bank output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 10 | Bus port number (0x10 selector, 0x11 window) |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Registered read data, valid with acknowledge |
| ecc_irq | output | 1 | ECC error interrupt level |
| dram_global_en | output | 1 | Global enable to the bank decoders |
| timing_cfg | output | 32 | Stored timing word |
| bank_cfg | output | 128 | Bank configuration words, bank 0 in the low bits |

## Verification
A single write to the configuration word can change both the enable bit and mode bit 30. The two status bits then update in the same cycle, in opposite directions. The bench provokes this with a directed write of 0xC0000000 from the reset value, which should give a status word of 0x40000000. It then writes 0 and expects 0x80000000. Random configuration writes that flip both bits in arbitrary combinations are judged against a bench model that applies each rule separately. Each window read, the enable and interrupt outputs are compared with that model after every access.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int DW = 32;

  localparam int OFS_ERR0  = 'h00;
  localparam int OFS_ERR1  = 'h08;
  localparam int OFS_EADR  = 'h10;
  localparam int OFS_CFG   = 'h20;
  localparam int OFS_STAT  = 'h24;
  localparam int OFS_RFSH  = 'h30;
  localparam int OFS_PWR   = 'h34;
  localparam int OFS_BANK0 = 'h40;
  localparam int OFS_BSTEP = 4;
  localparam int OFS_TMG   = 'h80;
  localparam int OFS_ECCC  = 'h94;
  localparam int OFS_ECCS  = 'h98;

  localparam logic [DW-1:0] CFG_MASK  = 32'hFFE0_0000;
  localparam logic [DW-1:0] RFSH_MASK = 32'h3FF8_0000;
  localparam logic [DW-1:0] PWR_MASK  = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_FORCE = 32'h07C0_0000;
  localparam logic [DW-1:0] TMG_MASK  = 32'h018F_C01F;
  localparam logic [DW-1:0] ECCC_MASK = 32'h00F0_0000;
  localparam logic [DW-1:0] ECCS_MASK = 32'hFFF0_F000;
  localparam logic [DW-1:0] BANK_MASK = 32'hFFDE_E001;

  localparam logic [DW-1:0] CFG_RST  = 32'h0080_0000;
  localparam logic [DW-1:0] RFSH_RST = 32'h05F0_0000;
  localparam logic [DW-1:0] TMG_RST  = 32'h0085_4009;

  localparam int EN_BIT   = 31;
  localparam int MODE_BIT = 30;
endpackage

// File: rtl/mcr_front.sv
module mcr_front #(
  parameter int PORT_W    = 10,
  parameter int OFS_W     = 8,
  parameter int DW        = 32,
  parameter int SEL_PORT  = 'h10,
  parameter int WIN_PORT  = 'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PORT_W-1:0] req_port,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     win_rdata,
  output logic [OFS_W-1:0]  ofs,
  output logic              win_wr,
  output logic              rsp_ack,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int PAD_W = DW - OFS_W;

  logic sel_hit, win_hit, sel_wr;
  logic [OFS_W-1:0] ofs_q;

  assign sel_hit = (req_port == PORT_W'(SEL_PORT));
  assign win_hit = (req_port == PORT_W'(WIN_PORT));
  assign sel_wr  = req_valid & req_write & sel_hit;
  assign win_wr  = req_valid & req_write & win_hit;
  assign ofs     = ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q     <= '0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack <= req_valid;
      if (sel_wr) ofs_q <= req_wdata[OFS_W-1:0];
      if (req_valid && !req_write) begin
        if (sel_hit)      rsp_rdata <= {{PAD_W{1'b0}}, ofs_q};
        else if (win_hit) rsp_rdata <= win_rdata;
        else              rsp_rdata <= '0;
      end
    end
  end

  // R2: offset only moves on a selector write
  a_r2_ofs_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && sel_hit) |=> $stable(ofs_q));
  // R2: acknowledge follows each request by one cycle
  a_r2_ack_timing: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ack);
  // R2: read data only changes after a read request
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

// File: rtl/mcr_bank_regs.sv
module mcr_bank_regs
  import mcr_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic             bank_hit,
  output logic [DW-1:0]    bank_rdata,
  output logic [NBANK*DW-1:0] bank_cfg
);
  logic [NBANK-1:0] hit_vec;
  logic [DW-1:0]    bank_q [NBANK];
  logic [DW-1:0]    masked [NBANK];

  genvar gi;
  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_bank
      assign hit_vec[gi] = (ofs == OFS_W'(OFS_BANK0 + OFS_BSTEP * gi));
      assign masked[gi]  = hit_vec[gi] ? bank_q[gi] : '0;
      assign bank_cfg[gi*DW +: DW] = bank_q[gi];

      always_ff @(posedge clk) begin
        if (rst) bank_q[gi] <= '0;
        else if (win_wr && hit_vec[gi]) bank_q[gi] <= wdata & BANK_MASK;
      end

      // R10: a write lands masked in the addressed bank
      a_r10_bank_write: assert property (@(posedge clk) disable iff (rst)
        (win_wr && hit_vec[gi]) |=> (bank_cfg[gi*DW +: DW] == ($past(wdata) & BANK_MASK)));
      // R10: other banks are untouched
      a_r10_bank_keep: assert property (@(posedge clk) disable iff (rst)
        !(win_wr && hit_vec[gi]) |=> $stable(bank_cfg[gi*DW +: DW]));
    end
  endgenerate

  always_comb begin
    bank_rdata = '0;
    for (int i = 0; i < NBANK; i++) bank_rdata = bank_rdata | masked[i];
  end
  assign bank_hit = |hit_vec;

  a_r10_hit_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/mcr_ecc_irq.sv
module mcr_ecc_irq
  import mcr_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    esr,
  output logic             irq
);
  logic          hit;
  logic [DW-1:0] esr_q, nv;
  logic          irq_q;

  assign hit = (ofs == OFS_W'(OFS_ECCS));
  assign nv  = wdata & ECCS_MASK;
  assign esr = esr_q;
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      esr_q <= '0;
      irq_q <= 1'b0;
    end else if (win_wr && hit) begin
      if (esr_q == '0 && nv != '0)      irq_q <= 1'b1;
      else if (esr_q != '0 && nv == '0) irq_q <= 1'b0;
      esr_q <= nv;
    end
  end

  // R8: interrupt level tracks a nonzero error word
  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_q == (esr_q != '0));
  // R8: interrupt only moves on a write to the error word
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(win_wr && hit) |=> $stable(irq_q));
endmodule

// File: rtl/mcr_ctrl_regs.sv
module mcr_ctrl_regs
  import mcr_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic             bank_hit,
  input  logic [DW-1:0]    bank_rdata,
  input  logic [DW-1:0]    ecc_rdata,
  output logic [DW-1:0]    win_rdata,
  output logic             glob_en,
  output logic [DW-1:0]    tmg_cfg
);
  logic [DW-1:0] err0_q, err1_q, eadr_q, cfg_q, stat_q;
  logic [DW-1:0] rfsh_q, pwr_q, tmg_q, eccc_q, cfg_nv;
  logic          en_q;
  logic          wr_cfg, wr_stat;

  assign cfg_nv  = wdata & CFG_MASK;
  assign wr_cfg  = win_wr && (ofs == OFS_W'(OFS_CFG));
  assign wr_stat = win_wr && (ofs == OFS_W'(OFS_STAT));
  assign glob_en = en_q;
  assign tmg_cfg = tmg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err0_q <= '0;
      err1_q <= '0;
      eadr_q <= '0;
      cfg_q  <= CFG_RST;
      stat_q <= '0;
      rfsh_q <= RFSH_RST;
      pwr_q  <= PWR_FORCE;
      tmg_q  <= TMG_RST;
      eccc_q <= '0;
      en_q   <= 1'b0;
    end else if (win_wr) begin
      case (ofs)
        OFS_W'(OFS_ERR0): err0_q <= err0_q & ~wdata;
        OFS_W'(OFS_ERR1): err1_q <= err1_q & ~wdata;
        OFS_W'(OFS_EADR): eadr_q <= wdata;
        OFS_W'(OFS_CFG): begin
          if (cfg_nv[EN_BIT] && !cfg_q[EN_BIT]) begin
            stat_q[EN_BIT] <= 1'b0;
            en_q           <= 1'b1;
          end else if (!cfg_nv[EN_BIT] && cfg_q[EN_BIT]) begin
            stat_q[EN_BIT] <= 1'b1;
            en_q           <= 1'b0;
          end
          if (cfg_nv[MODE_BIT] && !cfg_q[MODE_BIT])      stat_q[MODE_BIT] <= 1'b1;
          else if (!cfg_nv[MODE_BIT] && cfg_q[MODE_BIT]) stat_q[MODE_BIT] <= 1'b0;
          cfg_q <= cfg_nv;
        end
        OFS_W'(OFS_RFSH): rfsh_q <= wdata & RFSH_MASK;
        OFS_W'(OFS_PWR):  pwr_q  <= (wdata & PWR_MASK) | PWR_FORCE;
        OFS_W'(OFS_TMG):  tmg_q  <= wdata & TMG_MASK;
        OFS_W'(OFS_ECCC): eccc_q <= wdata & ECCC_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_W'(OFS_ERR0): win_rdata = err0_q;
      OFS_W'(OFS_ERR1): win_rdata = err1_q;
      OFS_W'(OFS_EADR): win_rdata = eadr_q;
      OFS_W'(OFS_CFG):  win_rdata = cfg_q;
      OFS_W'(OFS_STAT): win_rdata = stat_q;
      OFS_W'(OFS_RFSH): win_rdata = rfsh_q;
      OFS_W'(OFS_PWR):  win_rdata = pwr_q;
      OFS_W'(OFS_ECCC): win_rdata = eccc_q;
      OFS_W'(OFS_ECCS): win_rdata = ecc_rdata;
      default:          win_rdata = bank_hit ? bank_rdata : '1;
    endcase
  end

  // R4: enable rising edge clears status bit 31 and raises the enable
  a_r4_en_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && wdata[EN_BIT] && !cfg_q[EN_BIT]) |=> (glob_en && !stat_q[EN_BIT]));
  // R4: enable falling edge sets status bit 31 and drops the enable
  a_r4_en_fall: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wdata[EN_BIT] && cfg_q[EN_BIT]) |=> (!glob_en && stat_q[EN_BIT]));
  // R5: status bit 30 mirrors configuration bit 30
  a_r5_mode_mirror: assert property (@(posedge clk) disable iff (rst)
    stat_q[MODE_BIT] == cfg_q[MODE_BIT]);
  // R5: a write to the status word changes nothing in it
  a_r5_stat_ro: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> $stable(stat_q));
  // R7: forced power-management bits stay set
  a_r7_pwr_forced: assert property (@(posedge clk) disable iff (rst)
    (pwr_q & PWR_FORCE) == PWR_FORCE);
endmodule

// File: rtl/dram_csr_window.sv
module dram_csr_window
  import mcr_pkg::*;
#(
  parameter int PORT_W   = 10,
  parameter int OFS_W    = 8,
  parameter int NBANK    = 4,
  parameter int SEL_PORT = 'h10,
  parameter int WIN_PORT = 'h11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [PORT_W-1:0]   req_port,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_ack,
  output logic [DW-1:0]       rsp_rdata,
  output logic                ecc_irq,
  output logic                dram_global_en,
  output logic [DW-1:0]       timing_cfg,
  output logic [NBANK*DW-1:0] bank_cfg
);
  logic [OFS_W-1:0] ofs;
  logic             win_wr, bank_hit;
  logic [DW-1:0]    win_rdata, bank_rdata, ecc_rdata;

  mcr_front #(.PORT_W(PORT_W), .OFS_W(OFS_W), .DW(DW),
              .SEL_PORT(SEL_PORT), .WIN_PORT(WIN_PORT)) u_front (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_wdata(req_wdata), .win_rdata(win_rdata),
    .ofs(ofs), .win_wr(win_wr), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata));

  mcr_ctrl_regs #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst(rst), .win_wr(win_wr), .ofs(ofs), .wdata(req_wdata),
    .bank_hit(bank_hit), .bank_rdata(bank_rdata), .ecc_rdata(ecc_rdata),
    .win_rdata(win_rdata), .glob_en(dram_global_en), .tmg_cfg(timing_cfg));

  mcr_bank_regs #(.OFS_W(OFS_W), .NBANK(NBANK)) u_bank (
    .clk(clk), .rst(rst), .win_wr(win_wr), .ofs(ofs), .wdata(req_wdata),
    .bank_hit(bank_hit), .bank_rdata(bank_rdata), .bank_cfg(bank_cfg));

  mcr_ecc_irq #(.OFS_W(OFS_W)) u_ecc (
    .clk(clk), .rst(rst), .win_wr(win_wr), .ofs(ofs), .wdata(req_wdata),
    .esr(ecc_rdata), .irq(ecc_irq));
endmodule

// File: tb/sim_dram_csr_window.sv
module sim_dram_csr_window;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_port = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ack, ecc_irq, dram_global_en;
  logic [31:0] rsp_rdata, timing_cfg;
  logic [NB*32-1:0] bank_cfg;

  int checks = 0, errors = 0;

  // bench model
  logic [7:0]  m_ofs;
  logic [31:0] m_err0, m_err1, m_eadr, m_cfg, m_stat, m_rfsh, m_pwr, m_tmg, m_eccc, m_eccs;
  logic [31:0] m_bank [NB];
  logic        m_irq, m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_csr_window u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_wdata(req_wdata), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .ecc_irq(ecc_irq), .dram_global_en(dram_global_en),
    .timing_cfg(timing_cfg), .bank_cfg(bank_cfg));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ofs = 8'h00; m_err0 = 0; m_err1 = 0; m_eadr = 0; m_cfg = 32'h0080_0000;
    m_stat = 0; m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000; m_tmg = 32'h0085_4009;
    m_eccc = 0; m_eccs = 0; m_irq = 0; m_en = 0;
    for (int i = 0; i < NB; i++) m_bank[i] = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] o);
    case (o)
      8'h00: return m_err0;
      8'h08: return m_err1;
      8'h10: return m_eadr;
      8'h20: return m_cfg;
      8'h24: return m_stat;
      8'h30: return m_rfsh;
      8'h34: return m_pwr;
      8'h40: return m_bank[0];
      8'h44: return m_bank[1];
      8'h48: return m_bank[2];
      8'h4C: return m_bank[3];
      8'h94: return m_eccc;
      8'h98: return m_eccs;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] o, input logic [31:0] v);
    logic [31:0] nv;
    case (o)
      8'h00: m_err0 = m_err0 & ~v;
      8'h08: m_err1 = m_err1 & ~v;
      8'h10: m_eadr = v;
      8'h20: begin
        nv = v & 32'hFFE0_0000;
        if (nv[31] && !m_cfg[31]) begin m_stat[31] = 0; m_en = 1; end
        else if (!nv[31] && m_cfg[31]) begin m_stat[31] = 1; m_en = 0; end
        if (nv[30] && !m_cfg[30]) m_stat[30] = 1;
        else if (!nv[30] && m_cfg[30]) m_stat[30] = 0;
        m_cfg = nv;
      end
      8'h30: m_rfsh = v & 32'h3FF8_0000;
      8'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
      8'h40: m_bank[0] = v & 32'hFFDE_E001;
      8'h44: m_bank[1] = v & 32'hFFDE_E001;
      8'h48: m_bank[2] = v & 32'hFFDE_E001;
      8'h4C: m_bank[3] = v & 32'hFFDE_E001;
      8'h80: m_tmg = v & 32'h018F_C01F;
      8'h94: m_eccc = v & 32'h00F0_0000;
      8'h98: begin
        nv = v & 32'hFFF0_F000;
        if (m_eccs == 0 && nv != 0) m_irq = 1;
        else if (m_eccs != 0 && nv == 0) m_irq = 0;
        m_eccs = nv;
      end
      default: ;
    endcase
  endtask

  // one bus access; returns data and ack sampled one cycle later
  task automatic bus(input logic we, input logic [9:0] p, input logic [31:0] d,
                     output logic [31:0] r, output logic a);
    @(negedge clk);
    req_valid = 1; req_write = we; req_port = p; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    r = rsp_rdata; a = rsp_ack;
  endtask

  task automatic sel(input logic [31:0] v);
    logic [31:0] r; logic a;
    bus(1, 10'h10, v, r, a);
    m_ofs = v[7:0];
  endtask

  task automatic wwin(input logic [31:0] v);
    logic [31:0] r; logic a;
    bus(1, 10'h11, v, r, a);
    model_wr(m_ofs, v);
  endtask

  task automatic rwin(input string tag);
    logic [31:0] r; logic a;
    bus(0, 10'h11, 32'h0, r, a);
    chk(tag, r, exp_rd(m_ofs));
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " irq"}, ecc_irq, m_irq);
    chk({tag, " en"}, dram_global_en, m_en);
    chk({tag, " tmg"}, timing_cfg, m_tmg);
    chk({tag, " bank"}, bank_cfg, {m_bank[3], m_bank[2], m_bank[1], m_bank[0]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r; logic a;
    logic [7:0] olist [16];
    void'($urandom(32'd2718));
    olist = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30, 8'h34, 8'h40,
              8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98, 8'h5C, 8'hFF};
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    @(negedge clk);
    chk("R1 ack idle", rsp_ack, 1'b0);
    chk_outs("R1 outputs");
    bus(0, 10'h10, 0, r, a);
    chk("R1 selector", r, 32'h0);
    foreach (olist[k]) begin sel({24'h0, olist[k]}); rwin("R1 reset read"); end

    // R2 selector and handshake
    bus(1, 10'h10, 32'hABCD_EF20, r, a);
    m_ofs = 8'h20;
    chk("R2 ack on write", a, 1'b1);
    bus(0, 10'h10, 0, r, a);
    chk("R2 selector readback", r, 32'h20);
    chk("R2 ack on read", a, 1'b1);
    @(negedge clk);
    chk("R2 ack drops", rsp_ack, 1'b0);
    bus(1, 10'h03, 32'hFFFF_FFFF, r, a);
    bus(0, 10'h03, 0, r, a);
    chk("R2 other port read", r, 32'h0);
    rwin("R2 other port no effect");

    // R3 write-one-to-clear and error address
    sel(32'h00); wwin(32'hFFFF_FFFF); rwin("R3 err0");
    sel(32'h08); wwin(32'h5555_AAAA); rwin("R3 err1");
    sel(32'h10); wwin(32'h1234_5678); rwin("R3 error address");

    // R4/R5 enable and mode bit, incl. simultaneous flip
    sel(32'h20); wwin(32'h801F_FFFF); rwin("R4 cfg masked");
    chk_outs("R4 enable rise");
    sel(32'h24); rwin("R4 status after rise");
    sel(32'h20); wwin(32'h0);
    sel(32'h24); rwin("R4 status after fall");
    chk_outs("R4 enable fall");
    sel(32'h20); wwin(32'hC000_0000);
    sel(32'h24); rwin("R5 status both flipped 40000000");
    chk("R5 status value", rsp_rdata, 32'h4000_0000);
    sel(32'h20); wwin(32'h0);
    sel(32'h24); rwin("R5 status both cleared 80000000");
    chk("R5 status value2", rsp_rdata, 32'h8000_0000);
    wwin(32'h1234_5678); rwin("R5 status ignores write");

    // R6 masks
    sel(32'h30); wwin(32'hFFFF_FFFF); rwin("R6 refresh mask");
    sel(32'h94); wwin(32'hFFFF_FFFF); rwin("R6 ecc cfg mask");

    // R7 power-management
    sel(32'h34); wwin(32'h0); rwin("R7 pwr forced");
    wwin(32'hFFFF_FFFF); rwin("R7 pwr high bits");

    // R8 interrupt
    sel(32'h98); wwin(32'hFFFF_FFFF); rwin("R8 ecc mask");
    chk_outs("R8 irq rise");
    wwin(32'h0000_1000); chk_outs("R8 irq hold nonzero");
    wwin(32'h000F_0FFF); rwin("R8 masked to zero");
    chk_outs("R8 irq fall");

    // R9 timing and unmapped
    sel(32'h80); wwin(32'hFFFF_FFFF); rwin("R9 timing reads ones");
    chk_outs("R9 timing out");
    sel(32'h5C); wwin(32'h0); rwin("R9 unmapped");

    // R10 banks
    for (int b = 0; b < NB; b++) begin
      sel(32'h40 + 4*b); wwin(32'hFFFF_FFFF ^ (32'h1111_0000 << b)); rwin("R10 bank read");
    end
    chk_outs("R10 bank out");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] v;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 3) sel({$urandom_range(0, 255) << 8, olist[$urandom_range(0, 15)]});
      else if (pick < 7) begin
        v = $urandom();
        if ($urandom_range(0, 3) == 0) v = v & 32'hC000_0000;
        wwin(v);
      end else if (pick < 9) rwin("R2 random window read");
      else begin
        bus(0, 10'h10, 0, r, a);
        chk("R2 random selector read", r, {24'h0, m_ofs});
      end
      chk_outs("R4 R8 R9 R10 random outputs");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule